// File: doc/BRIEF.md
# Thread-Aware Insertion Protection Controller

This block sits beside the replacement logic of a set-associative cache that four hardware threads share. It keeps one signed pressure counter per thread and uses it to decide, on every cache fill, whether the newly installed block should start with its reference ("use") bit set. A set bit protects the block from the next sweep of the victim pointer. An unset bit leaves the block as the next candidate for eviction unless it is touched again.

The pressure counters move only on misses that land in the sets reserved for sampling this policy. The missing thread gains `NUM_THREADS-1` and every other thread loses one, so the counters always sum to zero. A thread whose counter is below zero misses less than its share and is classed as fragile. Its fills are always protected. Fills from the other threads are protected only while that thread's own wrapping throttle counter is below `THR_LIMIT`. With the default widths this protects one fill in 32, and the protected fills come in runs of 64.

The miss strobe, thread number and sampled-set flag come in together. The insertion decision for that miss is returned in the same cycle. Choosing the victim way and choosing among competing policies are done elsewhere.

Top module: `fragile_insert_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, all pressure counters and throttle counters are zero, so `fragile_o` is all zeros.
- R2: A miss with `miss_ded_i` high from thread j adds `NUM_THREADS-1` to thread j's pressure counter and subtracts 1 from every other thread's counter. Thread j is given by the binary value of `miss_tid_i`.
- R3: The pressure counters always sum to zero.
- R4: A miss with `miss_ded_i` low leaves every pressure counter unchanged.
- R5: `fragile_o[t]` is high exactly when thread t's pressure counter, read as two's complement of `PRES_W` bits, is negative.
- R6: If any counter would leave the signed `PRES_W`-bit range, that update is dropped entirely and no counter changes.
- R7: When `miss_vld_i` is high and the thread is fragile, `protect_o` is high.
- R8: When `miss_vld_i` is high and the thread is not fragile, `protect_o` is high exactly when that thread's throttle counter is below `THR_LIMIT`. The throttle value used is the one before this miss is counted.
- R9: Each thread's throttle counter counts up by one, modulo 2^`THR_W`, on every miss of that thread, whether in a sampled set or not. It holds on all other cycles.
- R10: `protect_o` is low whenever `miss_vld_i` is low.
- R11: Counter changes caused by a miss show up on `fragile_o` on the cycle after the clock edge that takes in the miss. The decision in `protect_o` is combinational from the inputs of the current cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_vld_i | input | 1 | A fill caused by a miss occurs this cycle |
| miss_tid_i | input | TID_W | Thread that missed (binary) |
| miss_ded_i | input | 1 | The miss is in a set reserved for sampling this policy |
| fragile_o | output | NUM_THREADS | Per-thread fragile classification |
| protect_o | output | 1 | Set the use bit of the incoming block |

## Verification
The bench builds the block with a 6-bit pressure counter, a 4-bit throttle counter and a throttle limit of 2. The counters therefore reach both ends of their range after a few dozen misses, which exercises the dropped-update rule at the positive and the negative limit. The short throttle period wraps many times within the run, so both halves of the throttle window occur often for every thread. The stimulus also places idle cycles and misses outside the sampled sets between sampled misses.

// File: rtl/ftd_pkg.sv
package ftd_pkg;

    typedef enum logic {
        INS_PLAIN     = 1'b0,
        INS_PROTECTED = 1'b1
    } ins_kind_e;

    typedef enum logic [1:0] {
        UPD_IDLE    = 2'd0,
        UPD_APPLY   = 2'd1,
        UPD_DROPPED = 2'd2
    } upd_kind_e;

    function automatic int tid_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int zero_sum_gain(input int n);
        return n - 1;
    endfunction

endpackage

// File: rtl/ftd_pressure_bank.sv
module ftd_pressure_bank
    import ftd_pkg::*;
#(
    parameter int NT = 4,
    parameter int CW = 14,
    parameter int TW = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [TW-1:0]    upd_tid,
    output logic [NT-1:0]    fragile,
    output logic [NT*CW-1:0] cnt_flat
);
    localparam int WW = CW + 2;
    localparam logic signed [WW-1:0] GAIN_W = WW'(zero_sum_gain(NT));
    localparam logic signed [WW-1:0] ONE_W  = WW'(1);
    localparam logic signed [WW-1:0] MAX_W  = WW'((2 ** (CW - 1)) - 1);
    localparam logic signed [WW-1:0] MIN_W  = -(WW'(2 ** (CW - 1)));

    logic signed [CW-1:0] cnt_q [NT];
    logic signed [WW-1:0] cur_w [NT];
    logic signed [WW-1:0] cand  [NT];
    logic [NT-1:0]        in_rng;
    upd_kind_e            upd_kind;

    always_comb begin
        if (!upd_en)       upd_kind = UPD_IDLE;
        else if (&in_rng)  upd_kind = UPD_APPLY;
        else               upd_kind = UPD_DROPPED;
    end

    for (genvar t = 0; t < NT; t++) begin : g_thr
        assign cur_w[t]  = WW'(cnt_q[t]);
        assign cand[t]   = (upd_tid == TW'(t)) ? (cur_w[t] + GAIN_W)
                                               : (cur_w[t] - ONE_W);
        assign in_rng[t] = (cand[t] <= MAX_W) && (cand[t] >= MIN_W);

        always_ff @(posedge clk) begin
            if (rst)
                cnt_q[t] <= '0;
            else if (upd_kind == UPD_APPLY)
                cnt_q[t] <= cand[t][CW-1:0];
        end

        assign fragile[t]             = cnt_q[t][CW-1];
        assign cnt_flat[t*CW +: CW]   = cnt_q[t];
    end

endmodule

// File: rtl/ftd_throttle_bank.sv
module ftd_throttle_bank #(
    parameter int NT    = 4,
    parameter int THW   = 11,
    parameter int LIMIT = 64,
    parameter int TW    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_vld,
    input  logic [TW-1:0]     miss_tid,
    output logic [NT-1:0]     open_win,
    output logic [NT*THW-1:0] thr_flat
);
    localparam logic [THW:0] LIMIT_W = (THW + 1)'(LIMIT);

    logic [THW-1:0] thr_q [NT];

    for (genvar t = 0; t < NT; t++) begin : g_thr
        always_ff @(posedge clk) begin
            if (rst)
                thr_q[t] <= '0;
            else if (miss_vld && (miss_tid == TW'(t)))
                thr_q[t] <= thr_q[t] + 1'b1;
        end

        assign open_win[t]             = {1'b0, thr_q[t]} < LIMIT_W;
        assign thr_flat[t*THW +: THW]  = thr_q[t];
    end

endmodule

// File: rtl/ftd_insert_select.sv
module ftd_insert_select
    import ftd_pkg::*;
#(
    parameter int NT = 4,
    parameter int TW = 2
) (
    input  logic          miss_vld,
    input  logic [TW-1:0] miss_tid,
    input  logic [NT-1:0] fragile,
    input  logic [NT-1:0] open_win,
    output ins_kind_e     kind
);
    logic frag_sel;
    logic open_sel;

    always_comb begin
        frag_sel = 1'b0;
        open_sel = 1'b0;
        for (int t = 0; t < NT; t++) begin
            if (miss_tid == TW'(t)) begin
                frag_sel = fragile[t];
                open_sel = open_win[t];
            end
        end
        kind = (miss_vld && (frag_sel || open_sel)) ? INS_PROTECTED : INS_PLAIN;
    end

endmodule

// File: rtl/fragile_insert_ctrl.sv
module fragile_insert_ctrl
    import ftd_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int PRES_W      = 14,
    parameter int THR_W       = 11,
    parameter int THR_LIMIT   = 64,
    localparam int TID_W      = tid_width(NUM_THREADS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   miss_vld_i,
    input  logic [TID_W-1:0]       miss_tid_i,
    input  logic                   miss_ded_i,
    output logic [NUM_THREADS-1:0] fragile_o,
    output logic                   protect_o
);
    logic [NUM_THREADS-1:0]        open_win;
    logic [NUM_THREADS*PRES_W-1:0] pres_flat;
    logic [NUM_THREADS*THR_W-1:0]  thr_flat;
    ins_kind_e                     kind;

    ftd_pressure_bank #(.NT(NUM_THREADS), .CW(PRES_W), .TW(TID_W)) u_pres (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (miss_vld_i && miss_ded_i),
        .upd_tid  (miss_tid_i),
        .fragile  (fragile_o),
        .cnt_flat (pres_flat)
    );

    ftd_throttle_bank #(.NT(NUM_THREADS), .THW(THR_W), .LIMIT(THR_LIMIT),
                        .TW(TID_W)) u_thr (
        .clk      (clk),
        .rst      (rst),
        .miss_vld (miss_vld_i),
        .miss_tid (miss_tid_i),
        .open_win (open_win),
        .thr_flat (thr_flat)
    );

    ftd_insert_select #(.NT(NUM_THREADS), .TW(TID_W)) u_sel (
        .miss_vld (miss_vld_i),
        .miss_tid (miss_tid_i),
        .fragile  (fragile_o),
        .open_win (open_win),
        .kind     (kind)
    );

    assign protect_o = (kind == INS_PROTECTED);

endmodule

// File: rtl/ftd_checker.sv
module ftd_checker #(
    parameter int NT  = 4,
    parameter int CW  = 14,
    parameter int THW = 11,
    parameter int TW  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              miss_vld,
    input logic [TW-1:0]     miss_tid,
    input logic              miss_ded,
    input logic [NT-1:0]     fragile,
    input logic              protect,
    input logic [NT*CW-1:0]  pres_flat,
    input logic [NT*THW-1:0] thr_flat
);
    int  pres_sum;
    logic frag_sel;

    always_comb begin
        pres_sum = 0;
        frag_sel = 1'b0;
        for (int t = 0; t < NT; t++) begin
            pres_sum = pres_sum + int'($signed(pres_flat[t*CW +: CW]));
            if (miss_tid == TW'(t)) frag_sel = fragile[t];
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (fragile == '0) && (pres_flat == '0) && (thr_flat == '0));

    p_zero_sum_r3: assert property (@(posedge clk) disable iff (rst)
        pres_sum == 0);

    p_follow_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(miss_vld && miss_ded) |=> $stable(pres_flat));

    p_fragile_protect_r7: assert property (@(posedge clk) disable iff (rst)
        (miss_vld && frag_sel) |-> protect);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !miss_vld |-> !protect);

    for (genvar t = 0; t < NT; t++) begin : g_thr
        p_thr_hold_r9: assert property (@(posedge clk) disable iff (rst)
            !(miss_vld && (miss_tid == TW'(t))) |=> $stable(thr_flat[t*THW +: THW]));

        p_thr_step_r9: assert property (@(posedge clk) disable iff (rst)
            (miss_vld && (miss_tid == TW'(t))) |=>
            (thr_flat[t*THW +: THW] == THW'($past(thr_flat[t*THW +: THW]) + 1'b1)));
    end

endmodule

bind fragile_insert_ctrl ftd_checker #(
    .NT  (NUM_THREADS),
    .CW  (PRES_W),
    .THW (THR_W),
    .TW  (TID_W)
) u_ftd_chk (
    .clk       (clk),
    .rst       (rst),
    .miss_vld  (miss_vld_i),
    .miss_tid  (miss_tid_i),
    .miss_ded  (miss_ded_i),
    .fragile   (fragile_o),
    .protect   (protect_o),
    .pres_flat (pres_flat),
    .thr_flat  (thr_flat)
);

// File: tb/tb_fragile_insert_ctrl.sv
module tb_fragile_insert_ctrl;
    localparam int NT    = 4;
    localparam int CW    = 6;
    localparam int THW   = 4;
    localparam int LIM   = 2;
    localparam int TW    = 2;
    localparam int PMAX  = (2 ** (CW - 1)) - 1;
    localparam int PMIN  = -(2 ** (CW - 1));
    localparam int TMOD  = 2 ** THW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          miss_vld = 1'b0;
    logic [TW-1:0] miss_tid = '0;
    logic          miss_ded = 1'b0;
    logic [NT-1:0] fragile;
    logic          protect;

    int n_checks = 0;
    int n_fail   = 0;
    int pres [NT];
    int thr  [NT];
    string last_tag = "R1";

    always #2.5 clk = ~clk;

    fragile_insert_ctrl #(
        .NUM_THREADS (NT),
        .PRES_W      (CW),
        .THR_W       (THW),
        .THR_LIMIT   (LIM)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .miss_vld_i (miss_vld),
        .miss_tid_i (miss_tid),
        .miss_ded_i (miss_ded),
        .fragile_o  (fragile),
        .protect_o  (protect)
    );

    function automatic logic [NT-1:0] exp_fragile();
        logic [NT-1:0] f;
        for (int t = 0; t < NT; t++) f[t] = (pres[t] < 0);
        return f;
    endfunction

    task automatic check_frag(input string tag);
        n_checks++;
        if (fragile !== exp_fragile()) begin
            n_fail++;
            $display("FAIL %s R5 fragile_o actual=%b expected=%b", tag, fragile, exp_fragile());
        end
    endtask

    // One cycle: drive at the falling edge, check, then let the rising edge take it in.
    task automatic step(input bit vld, input int tid, input bit ded);
        bit    exp_p;
        string ptag;
        bit    ok;
        int    cand [NT];
        miss_vld = vld;
        miss_tid = TW'(tid);
        miss_ded = ded;
        #1;
        // R11: fragile_o reflects every update taken at earlier edges
        check_frag(last_tag);
        if (!vld) begin
            exp_p = 1'b0; ptag = "R10";
        end else if (pres[tid] < 0) begin
            exp_p = 1'b1; ptag = "R7";
        end else begin
            exp_p = (thr[tid] < LIM); ptag = "R8";
        end
        n_checks++;
        if (protect !== exp_p) begin
            n_fail++;
            $display("FAIL %s protect_o actual=%b expected=%b (tid %0d)", ptag, protect, exp_p, tid);
        end
        @(posedge clk);
        if (vld) begin
            thr[tid] = (thr[tid] + 1) % TMOD;   // R9
            if (ded) begin
                ok = 1'b1;
                for (int t = 0; t < NT; t++) begin
                    cand[t] = (t == tid) ? pres[t] + NT - 1 : pres[t] - 1;
                    if (cand[t] > PMAX || cand[t] < PMIN) ok = 1'b0;
                end
                if (ok) begin
                    for (int t = 0; t < NT; t++) pres[t] = cand[t];  // R2, sum stays zero (R3)
                    last_tag = "R2";
                end else begin
                    last_tag = "R6";
                end
            end else begin
                last_tag = "R4";
            end
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        for (int t = 0; t < NT; t++) begin
            pres[t] = 0;
            thr[t]  = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        n_checks++;
        if (fragile !== '0) begin
            n_fail++;
            $display("FAIL R1 fragile_o actual=%b expected=0", fragile);
        end
        step(1'b0, 0, 1'b0);
        // Thread 0 drives its counter to the top; later updates are dropped (R6)
        for (int i = 0; i < 14; i++) step(1'b1, 0, 1'b1);
        // Follower-set misses leave pressure alone (R4), run the throttles (R8, R9)
        for (int i = 0; i < 24; i++) step(1'b1, i % NT, 1'b0);
        // Other threads push thread 0 down to the bottom of its range (R6)
        for (int i = 0; i < 90; i++) step(1'b1, 1 + (i % 3), 1'b1);
        for (int i = 0; i < 8; i++) step(1'b0, 0, 1'b1);
        // Mixed traffic
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 20)      step(1'b0, $urandom_range(0, NT-1), $urandom_range(0, 1));
            else if (r < 55) step(1'b1, $urandom_range(0, NT-1), 1'b0);
            else if (r < 75) step(1'b1, $urandom_range(0, 1), 1'b1);
            else             step(1'b1, $urandom_range(0, NT-1), 1'b1);
        end
        // Mid-run reset returns everything to zero (R1)
        rst = 1'b1;
        for (int t = 0; t < NT; t++) begin
            pres[t] = 0;
            thr[t]  = 0;
        end
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        last_tag = "R1";
        for (int i = 0; i < 40; i++) step(1'b1, i % NT, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule